// File: doc/BRIEF.md
# Timer Control and Flag Unit with Access-Triggered Clearing

This block is the control and status core of a multi-channel timer. It holds one control byte that switches the timer on, chooses whether the timer stops in the low-power wait state and in the debug freeze state, and selects an access-triggered flag clearing mode. From that byte and the two state inputs it gates a 16-bit free-running counter behind a fixed prescaler. It also gates a divide-by-64 tick that feeds a pulse accumulator, and it produces run enables for the pulse accumulators and for a modulus down counter.

It holds the sticky status flags of the timer: one per capture/compare channel, a counter overflow flag, an overflow flag and an input-edge flag for the first pulse accumulator, and an overflow flag for the second. Neighbouring datapaths raise these flags with single-cycle event pulses. Software lowers them through a byte-wide register bus. In the normal mode a flag drops only when a one is written to its bit. In the access-triggered mode a flag also drops when software touches the data register that goes with it, so no separate clearing write is needed.

Top module: `timer_flag_unit`

## Requirements
- R1: The control byte at address 0x06 holds timer-on in bit 7, stop-in-wait in bit 6, stop-in-freeze in bit 5 and access-clear mode in bit 4. Bits 3..0 read as 0. All bits reset to 0, and the byte can be written and read at any time.
- R2: The 16-bit counter resets to 0 and reads as its high byte at 0x04 and its low byte at 0x05. It advances by one every PRESCALE clock cycles only while timer-on is 1, not (stop-in-wait and wait_i), and not (stop-in-freeze and frz_i). Otherwise it holds its value.
- R3: When the counter steps from 0xFFFF to 0x0000, the overflow flag sets. It reads as bit 7 of address 0x0F.
- R4: `pa_tick_o` pulses once every 64 cycles while timer-on is 1 and not (stop-in-wait and wait_i). It stays low otherwise. Freeze does not stop it.
- R5: `pa_run_o` is low exactly when stop-in-wait and wait_i are both 1. `mdc_run_o` is low when that holds or when stop-in-freeze and frz_i are both 1.
- R6: A pulse on ch_evt_i[i] sets channel flag i, which reads as bit i of 0x0E. pa_ovf_evt_i sets bit 1 and pa_edge_evt_i sets bit 0 of 0x21. pb_ovf_evt_i sets bit 1 of 0x31.
- R7: In either mode, writing a byte to 0x0E, 0x0F, 0x21 or 0x31 clears each flag whose bit is 1 in the byte. Bits written as 0 leave their flags unchanged.
- R8: With access-clear mode 0, reads and writes of the counter, channel and accumulator-count addresses leave every flag unchanged.
- R9: With access-clear mode 1, channel i owns the addresses 0x10+2i and 0x11+2i. If ch_oc_i[i] is 0 (capture), a read of either address clears flag i and a write does not. If ch_oc_i[i] is 1 (compare), a write clears flag i and a read does not.
- R10: With access-clear mode 1, a read or write of 0x04 or 0x05 clears the counter overflow flag.
- R11: With access-clear mode 1, a read or write of 0x22 or 0x23 clears both flags of 0x21. A read or write of 0x24 or 0x25 clears the flag of 0x31. Neither access touches the other accumulator's flags.
- R12: When a set event and a clearing access reach the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | 8 | Register address |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| wait_i | input | 1 | Device is in the wait state |
| frz_i | input | 1 | Device is in the debug freeze state |
| ch_oc_i | input | NCH | Per channel: 1 = compare, 0 = capture |
| ch_evt_i | input | NCH | Per-channel capture/compare event pulses |
| pa_ovf_evt_i | input | 1 | First accumulator overflow pulse |
| pa_edge_evt_i | input | 1 | First accumulator input-edge pulse |
| pb_ovf_evt_i | input | 1 | Second accumulator overflow pulse |
| cnt_o | output | 16 | Free-running counter value |
| cnt_tick_o | output | 1 | Counter advances on this cycle |
| pa_tick_o | output | 1 | Divide-by-64 tick for the accumulator |
| pa_run_o | output | 1 | Accumulators may run |
| mdc_run_o | output | 1 | Modulus down counter may run |
| ch_flag_o | output | NCH | Channel flags |
| tof_o | output | 1 | Counter overflow flag |
| pa_ovf_flag_o | output | 1 | First accumulator overflow flag |
| pa_edge_flag_o | output | 1 | First accumulator input-edge flag |
| pb_ovf_flag_o | output | 1 | Second accumulator overflow flag |

## Verification
The assertions check the following on every cycle. A halted counter never moves and a running one only steps by one. A wrap always leaves the overflow flag set. The accumulator tick never fires while its clock is gated. The control byte's low nibble reads as zero. A channel flag never drops unless there was a flag write or access-clear mode was on. A set event always wins the cycle. Only the bench scenarios can show which exact address and direction clears which flag. They also show that the capture/compare split is honoured, that the two accumulators' flags stay apart, and that tick rates come out right across wait and freeze combinations.

// File: rtl/tfu_pkg.sv
package tfu_pkg;
  localparam int CNT_W = 16;

  localparam logic [7:0] A_CNT_HI   = 8'h04;
  localparam logic [7:0] A_CNT_LO   = 8'h05;
  localparam logic [7:0] A_CTRL     = 8'h06;
  localparam logic [7:0] A_CHFLG    = 8'h0E;
  localparam logic [7:0] A_OVFLG    = 8'h0F;
  localparam logic [7:0] A_CH_BASE  = 8'h10;
  localparam logic [7:0] A_PAFLG    = 8'h21;
  localparam logic [7:0] A_PACNT_HI = 8'h22;
  localparam logic [7:0] A_PACNT_LO = 8'h23;
  localparam logic [7:0] A_PBCNT_HI = 8'h24;
  localparam logic [7:0] A_PBCNT_LO = 8'h25;
  localparam logic [7:0] A_PBFLG    = 8'h31;

  typedef struct packed {
    logic run_en;
    logic wait_stop;
    logic frz_stop;
    logic fast_clr;
  } ctrl_t;

  function automatic logic [7:0] ctrl_byte(input ctrl_t c);
    return {c.run_en, c.wait_stop, c.frz_stop, c.fast_clr, 4'b0000};
  endfunction

  // channel idx owns the byte pair A_CH_BASE + 2*idx, +1
  function automatic logic chan_hit(input logic [7:0] a, input int idx);
    return (int'(a) >> 1) == ((int'(A_CH_BASE) >> 1) + idx);
  endfunction

  function automatic logic pair_hit(input logic [7:0] a, input logic [7:0] hi,
                                    input logic [7:0] lo);
    return (a == hi) || (a == lo);
  endfunction

  function automatic logic at_wrap(input logic [CNT_W-1:0] c);
    return &c;
  endfunction
endpackage

// File: rtl/tfu_timebase.sv
module tfu_timebase
  import tfu_pkg::*;
#(
  parameter int PRESCALE = 4,
  parameter int PA_DIV   = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_t            ctl,
  input  logic             wait_i,
  input  logic             frz_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             cnt_tick_o,
  output logic             wrap_evt_o,
  output logic             pa_tick_o,
  output logic             pa_run_o,
  output logic             mdc_run_o
);
  localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int PD_W = (PA_DIV > 1) ? $clog2(PA_DIV) : 1;

  logic [PS_W-1:0] ps_q;
  logic [PD_W-1:0] pd_q;
  logic            in_wait_stop, in_frz_stop, main_run, pa_clk_en, ps_last;

  assign in_wait_stop = ctl.wait_stop & wait_i;
  assign in_frz_stop  = ctl.frz_stop & frz_i;
  assign main_run     = ctl.run_en & ~in_wait_stop & ~in_frz_stop;
  assign pa_clk_en    = ctl.run_en & ~in_wait_stop;
  assign pa_run_o     = ~in_wait_stop;
  assign mdc_run_o    = ~in_wait_stop & ~in_frz_stop;

  assign ps_last    = (ps_q == PS_W'(PRESCALE - 1));
  assign cnt_tick_o = main_run & ps_last;
  assign wrap_evt_o = cnt_tick_o & at_wrap(cnt_o);
  assign pa_tick_o  = pa_clk_en & (pd_q == PD_W'(PA_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps_q  <= '0;
      pd_q  <= '0;
      cnt_o <= '0;
    end else begin
      if (main_run) ps_q <= ps_last ? '0 : ps_q + 1'b1;
      if (pa_clk_en) pd_q <= pa_tick_o ? '0 : pd_q + 1'b1;
      if (cnt_tick_o) cnt_o <= cnt_o + 1'b1;
    end
  end

  // R2
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !main_run |=> $stable(cnt_o));
  // R2
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_tick_o |=> (cnt_o == $past(cnt_o) + 1'b1));
  // R4
  pa_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pa_clk_en |-> !pa_tick_o);
endmodule

// File: rtl/tfu_flags.sv
module tfu_flags #(
  parameter int NF = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] clr_i,
  output logic [NF-1:0] flag_o
);
  for (genvar k = 0; k < NF; k++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) flag_o[k] <= 1'b0;
      else if (set_i[k]) flag_o[k] <= 1'b1;
      else if (clr_i[k]) flag_o[k] <= 1'b0;
    end
  end

  // R12
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((flag_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/timer_flag_unit.sv
module timer_flag_unit
  import tfu_pkg::*;
#(
  parameter int NCH      = 8,
  parameter int PRESCALE = 4,
  parameter int PA_DIV   = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       addr_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o,
  input  logic             wait_i,
  input  logic             frz_i,
  input  logic [NCH-1:0]   ch_oc_i,
  input  logic [NCH-1:0]   ch_evt_i,
  input  logic             pa_ovf_evt_i,
  input  logic             pa_edge_evt_i,
  input  logic             pb_ovf_evt_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             cnt_tick_o,
  output logic             pa_tick_o,
  output logic             pa_run_o,
  output logic             mdc_run_o,
  output logic [NCH-1:0]   ch_flag_o,
  output logic             tof_o,
  output logic             pa_ovf_flag_o,
  output logic             pa_edge_flag_o,
  output logic             pb_ovf_flag_o
);
  localparam int NF    = NCH + 4;
  localparam int I_TOF = NCH;
  localparam int I_PAO = NCH + 1;
  localparam int I_PAE = NCH + 2;
  localparam int I_PBO = NCH + 3;

  ctrl_t           ctl;
  logic            acc, fast, wrap_evt;
  logic [NF-1:0]   set_v, clr_v, flag_v;

  always_ff @(posedge clk) begin
    if (!rst_n) ctl <= '0;
    else if (wr_i && addr_i == A_CTRL) ctl <= ctrl_t'(wdata_i[7:4]);
  end

  tfu_timebase #(.PRESCALE(PRESCALE), .PA_DIV(PA_DIV)) u_tb (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .wait_i(wait_i), .frz_i(frz_i),
    .cnt_o(cnt_o), .cnt_tick_o(cnt_tick_o), .wrap_evt_o(wrap_evt),
    .pa_tick_o(pa_tick_o), .pa_run_o(pa_run_o), .mdc_run_o(mdc_run_o)
  );

  assign acc  = rd_i | wr_i;
  assign fast = ctl.fast_clr;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign set_v[i] = ch_evt_i[i];
    assign clr_v[i] = (wr_i && addr_i == A_CHFLG && wdata_i[i]) ||
                      (fast && chan_hit(addr_i, i) && (ch_oc_i[i] ? wr_i : rd_i));
  end

  assign set_v[I_TOF] = wrap_evt;
  assign set_v[I_PAO] = pa_ovf_evt_i;
  assign set_v[I_PAE] = pa_edge_evt_i;
  assign set_v[I_PBO] = pb_ovf_evt_i;

  assign clr_v[I_TOF] = (wr_i && addr_i == A_OVFLG && wdata_i[7]) ||
                        (fast && acc && pair_hit(addr_i, A_CNT_HI, A_CNT_LO));
  assign clr_v[I_PAO] = (wr_i && addr_i == A_PAFLG && wdata_i[1]) ||
                        (fast && acc && pair_hit(addr_i, A_PACNT_HI, A_PACNT_LO));
  assign clr_v[I_PAE] = (wr_i && addr_i == A_PAFLG && wdata_i[0]) ||
                        (fast && acc && pair_hit(addr_i, A_PACNT_HI, A_PACNT_LO));
  assign clr_v[I_PBO] = (wr_i && addr_i == A_PBFLG && wdata_i[1]) ||
                        (fast && acc && pair_hit(addr_i, A_PBCNT_HI, A_PBCNT_LO));

  tfu_flags #(.NF(NF)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(set_v), .clr_i(clr_v), .flag_o(flag_v)
  );

  assign ch_flag_o      = flag_v[NCH-1:0];
  assign tof_o          = flag_v[I_TOF];
  assign pa_ovf_flag_o  = flag_v[I_PAO];
  assign pa_edge_flag_o = flag_v[I_PAE];
  assign pb_ovf_flag_o  = flag_v[I_PBO];

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL:   rdata_o = ctrl_byte(ctl);
      A_CNT_HI: rdata_o = cnt_o[15:8];
      A_CNT_LO: rdata_o = cnt_o[7:0];
      A_CHFLG:  for (int i = 0; i < NCH; i++) rdata_o[i] = ch_flag_o[i];
      A_OVFLG:  rdata_o[7] = tof_o;
      A_PAFLG:  rdata_o[1:0] = {pa_ovf_flag_o, pa_edge_flag_o};
      A_PBFLG:  rdata_o[1] = pb_ovf_flag_o;
      default:  rdata_o = '0;
    endcase
  end

  // R1
  ctrl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == A_CTRL) |-> (rdata_o[3:0] == 4'h0));
  // R3
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> tof_o);
  // R8
  ch_drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(ch_flag_o) & ~ch_flag_o)) |-> $past((wr_i && addr_i == A_CHFLG) || fast));
endmodule

// File: tb/timer_flag_unit_tb_top.sv
module timer_flag_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr_i = '0, wdata_i = '0, rdata_o;
  logic        rd_i = 1'b0, wr_i = 1'b0, wait_i = 1'b0, frz_i = 1'b0;
  logic [7:0]  ch_oc_i = '0, ch_evt_i = '0, ch_flag_o;
  logic        pa_ovf_evt_i = 1'b0, pa_edge_evt_i = 1'b0, pb_ovf_evt_i = 1'b0;
  logic [15:0] cnt_o;
  logic        cnt_tick_o, pa_tick_o, pa_run_o, mdc_run_o;
  logic        tof_o, pa_ovf_flag_o, pa_edge_flag_o, pb_ovf_flag_o;
  int          nvec = 0, nerr = 0;

  always #2 clk = ~clk;

  timer_flag_unit #(.NCH(8), .PRESCALE(1), .PA_DIV(64)) dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk); wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr_i = a; rd_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk); rd_i = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] ch, input logic pao, input logic pae, input logic pbo);
    @(negedge clk); ch_evt_i = ch; pa_ovf_evt_i = pao; pa_edge_evt_i = pae; pb_ovf_evt_i = pbo;
    @(negedge clk); ch_evt_i = '0; pa_ovf_evt_i = 0; pa_edge_evt_i = 0; pb_ovf_evt_i = 0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    bus_rd(8'h06, d); chk("R1 reset ctrl", d, 8'h00);
    chk("R2 reset count", cnt_o, 16'h0000);
    chk("R6 reset flags", {ch_flag_o, tof_o, pa_ovf_flag_o, pa_edge_flag_o, pb_ovf_flag_o}, 0);
  endtask

  task automatic t_ctrl;
    logic [7:0] d;
    bus_wr(8'h06, 8'hFF); bus_rd(8'h06, d); chk("R1 ctrl readback", d, 8'hF0);
    bus_wr(8'h06, 8'h00); bus_rd(8'h06, d); chk("R1 ctrl cleared", d, 8'h00);
  endtask

  task automatic t_count;
    logic [15:0] c0;
    logic [7:0] hi, lo;
    @(negedge clk); c0 = cnt_o;
    repeat (20) @(negedge clk);
    chk("R2 halted when off", cnt_o, c0);
    bus_wr(8'h06, 8'h80);
    @(negedge clk); c0 = cnt_o;
    repeat (40) @(negedge clk);
    chk("R2 runs one per cycle", cnt_o - c0, 40);
    wait_i = 1'b1;
    @(negedge clk); c0 = cnt_o;
    repeat (10) @(negedge clk);
    chk("R2 wait without stop bit", cnt_o - c0, 10);
    wait_i = 1'b0;
    bus_wr(8'h06, 8'h00);
    @(negedge clk); c0 = cnt_o;
    bus_rd(8'h04, hi); bus_rd(8'h05, lo);
    chk("R2 byte reads", {hi, lo}, c0);
  endtask

  task automatic count_pa(input int cycles, output int n);
    n = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk); if (pa_tick_o) n++;
    end
  endtask

  task automatic t_halts;
    logic [15:0] c0;
    int n;
    count_pa(640, n); chk("R4 no tick when off", n, 0);
    bus_wr(8'h06, 8'hA0);
    frz_i = 1'b1;
    @(negedge clk); c0 = cnt_o;
    count_pa(640, n);
    chk("R2 freeze halts count", cnt_o, c0);
    chk("R4 tick survives freeze", n, 10);
    chk("R5 freeze stops modulus", mdc_run_o, 0);
    chk("R5 freeze keeps accumulator", pa_run_o, 1);
    frz_i = 1'b0;
    bus_wr(8'h06, 8'hC0);
    wait_i = 1'b1;
    @(negedge clk); c0 = cnt_o;
    count_pa(200, n);
    chk("R2 wait halts count", cnt_o, c0);
    chk("R4 wait stops tick", n, 0);
    chk("R5 wait stops all", {pa_run_o, mdc_run_o}, 2'b00);
    wait_i = 1'b0;
    @(negedge clk);
    chk("R5 released", {pa_run_o, mdc_run_o}, 2'b11);
    bus_wr(8'h06, 8'h00);
  endtask

  task automatic t_normal_clear;
    logic [7:0] d;
    pulse(8'h0C, 1, 1, 1);
    bus_rd(8'h0E, d); chk("R6 channel flags", d, 8'h0C);
    bus_rd(8'h21, d); chk("R6 acc A flags", d, 8'h03);
    bus_rd(8'h31, d); chk("R6 acc B flag", d, 8'h02);
    bus_rd(8'h17, d); bus_wr(8'h16, 8'h55); bus_rd(8'h22, d); bus_wr(8'h25, 8'h00);
    chk("R8 data access keeps flags", {ch_flag_o, pa_ovf_flag_o, pa_edge_flag_o, pb_ovf_flag_o}, 11'h067);
    bus_wr(8'h0E, 8'h00); chk("R7 zero write keeps", ch_flag_o, 8'h0C);
    bus_wr(8'h0E, 8'h08); chk("R7 one write clears bit3", ch_flag_o, 8'h04);
    bus_wr(8'h21, 8'h01); chk("R7 edge flag cleared", {pa_ovf_flag_o, pa_edge_flag_o}, 2'b10);
    bus_wr(8'h21, 8'h02); bus_wr(8'h31, 8'h02); bus_wr(8'h0E, 8'hFF);
    chk("R7 all cleared", {ch_flag_o, pa_ovf_flag_o, pa_edge_flag_o, pb_ovf_flag_o}, 0);
  endtask

  task automatic t_fast_channel;
    logic [7:0] d;
    ch_oc_i = 8'h20;
    bus_wr(8'h06, 8'h10);
    pulse(8'h2C, 0, 0, 0);
    bus_wr(8'h16, 8'h00); chk("R9 capture write keeps", ch_flag_o[3], 1);
    bus_rd(8'h17, d);     chk("R9 capture read clears", ch_flag_o[3], 0);
    bus_rd(8'h1A, d);     chk("R9 compare read keeps", ch_flag_o[5], 1);
    bus_wr(8'h1B, 8'h00); chk("R9 compare write clears", ch_flag_o[5], 0);
    chk("R9 other channel untouched", ch_flag_o, 8'h04);
    bus_wr(8'h0E, 8'h04); chk("R7 write clears in fast mode", ch_flag_o, 8'h00);
    ch_oc_i = 8'h00;
  endtask

  task automatic t_fast_acc;
    logic [7:0] d;
    pulse(8'h00, 1, 1, 1);
    bus_rd(8'h25, d);
    chk("R11 acc B cleared", pb_ovf_flag_o, 0);
    chk("R11 acc A kept", {pa_ovf_flag_o, pa_edge_flag_o}, 2'b11);
    pulse(8'h00, 0, 0, 1);
    bus_wr(8'h22, 8'h00);
    chk("R11 acc A both cleared", {pa_ovf_flag_o, pa_edge_flag_o}, 2'b00);
    chk("R11 acc B kept", pb_ovf_flag_o, 1);
    bus_wr(8'h24, 8'h00);
    chk("R11 acc B write clears", pb_ovf_flag_o, 0);
  endtask

  task automatic t_set_wins;
    @(negedge clk); ch_evt_i = 8'h08; addr_i = 8'h16; rd_i = 1'b1;
    @(negedge clk); ch_evt_i = '0; rd_i = 1'b0;
    chk("R12 set beats access clear", ch_flag_o[3], 1);
    @(negedge clk); ch_evt_i = 8'h08; addr_i = 8'h0E; wdata_i = 8'h08; wr_i = 1'b1;
    @(negedge clk); ch_evt_i = '0; wr_i = 1'b0;
    chk("R12 set beats write clear", ch_flag_o[3], 1);
    bus_wr(8'h0E, 8'h08);
    chk("R12 cleared afterwards", ch_flag_o[3], 0);
  endtask

  task automatic run_to_wrap(input string req);
    while (cnt_o != 16'hFFFF) @(negedge clk);
    chk(req, tof_o, 0);
    @(negedge clk);
    chk("R3 wrap to zero", cnt_o, 16'h0000);
    chk("R3 overflow flag set", tof_o, 1);
  endtask

  task automatic t_overflow;
    logic [7:0] d;
    bus_wr(8'h06, 8'h80);
    run_to_wrap("R3 flag low before wrap");
    bus_rd(8'h05, d); bus_wr(8'h04, 8'h00);
    chk("R8 counter access keeps overflow", tof_o, 1);
    bus_wr(8'h0F, 8'h7F); chk("R7 zero bit keeps overflow", tof_o, 1);
    bus_wr(8'h0F, 8'h80); chk("R7 overflow cleared", tof_o, 0);
    bus_wr(8'h06, 8'h90);
    run_to_wrap("R3 flag low before second wrap");
    bus_rd(8'h0F, d); chk("R3 overflow at bit 7", d, 8'h80);
    bus_rd(8'h04, d); chk("R10 counter read clears", tof_o, 0);
    bus_wr(8'h06, 8'h00);
  endtask

  initial begin
    for (int k = 0; k < 190000; k++) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl();
    t_count();
    t_halts();
    t_normal_clear();
    t_fast_channel();
    t_fast_acc();
    t_set_wins();
    t_overflow();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule